// File: doc/BRIEF.md
# Linked-Pair Buffered PWM Channel

This block pairs two compare channels that share one up-counter and its overflow strobe. Unlinked, each channel runs on its own: it compares the counter against its own compare register and changes its output on a match (toggle, clear or set) and, if enabled, toggles it on every overflow. With a 16-bit value held in each compare register, software loads a register as a high byte followed by a low byte. The low-byte write completes the load.

Linked, the two compare registers feed the even channel's output alone, and the odd channel lets go of its pin. One register is active and the other is free for the next pulse width. A completed write to the free register arms a swap. The swap happens only at the next counter overflow, so every period is produced from one consistent width, even when the width jumps from nearly full to nearly empty. A read-only indicator tells software which register is active. The counter and the register decode sit outside this block.

Top module: `pwm_pair_buf`

## Requirements
- R1: After reset both channel outputs are 0, the active-register indicator is 0 (even register active), the odd-release flag is 0, and with all configuration inputs at 0 neither output enable is high.
- R2: One cycle after the link input is raised, the odd-release flag is 1. The odd channel's output enable is then 0 and its output stays frozen, whatever its own mode, action and overflow settings are. The even channel drives its output whether or not its own mode-A input is set.
- R3: A compare register takes a new value only when its low byte is written, and it combines that byte with the high byte staged earlier. A high-byte write alone changes neither the waveform nor, when linked, the active register.
- R4: Unlinked, with the even action set to clear (code 2'b10) and toggle-on-overflow on, the even output is high for exactly C cycles of every period of MOD+1 counts, where C (1..MOD) is the compare value.
- R5: When linking starts, the even register is active. A completed write to the inactive register makes that register the width source from the first period after the next overflow, and the indicator (0 even, 1 odd) flips at that overflow and at no other time.
- R6: If the inactive register is written several times before an overflow, the last completed value is the one used.
- R7: Linked, with a period of 256 counts, the width moves from 254 to 1 in a single period.
- R8: A toggle on overflow takes precedence over a compare action in the same cycle. A compare value above the counter's range never matches, so the output only toggles at each overflow.
- R9: The toggle (code 2'b01) and set (code 2'b11) compare actions toggle or set the channel output in the cycle after the counter equals the compare value. Code 2'b00 drives nothing.
- R10: In the cycle after the link input falls, the indicator returns to 0 and the odd-release flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Shared counter value |
| ovf_i | input | 1 | Overflow strobe, high in the cycle the counter shows 0 after wrapping |
| link_en_i | input | 1 | Links the pair (even channel's mode-B) |
| even_mode_a_i | input | 1 | Even channel output-compare mode; ignored while linked |
| even_act_i | input | 2 | Even compare action: 00 none, 01 toggle, 10 clear, 11 set |
| even_tov_i | input | 1 | Even channel toggle on overflow |
| odd_mode_a_i | input | 1 | Odd channel output-compare mode |
| odd_act_i | input | 2 | Odd compare action, same codes |
| odd_tov_i | input | 1 | Odd channel toggle on overflow |
| wr_en_i | input | 1 | Compare register byte write strobe |
| wr_odd_i | input | 1 | Write target: 0 even register, 1 odd register |
| wr_hi_i | input | 1 | 1 high byte (staged), 0 low byte (completes) |
| wr_data_i | input | 8 | Write byte |
| pwm_o | output | 2 | Channel outputs, bit 0 even, bit 1 odd |
| pwm_oe_o | output | 2 | Channel output enables |
| odd_port_ctl_o | output | 1 | Odd pin released to general-purpose I/O |
| act_sel_o | output | 1 | Active width register: 0 even, 1 odd |

## Verification
An output change is due one cycle after the counter value or the overflow strobe that causes it. So the bench drives each count on a falling edge and reads the output at the next falling edge, and it counts high samples over windows of MOD+1 counts that begin with the overflow. A completed write takes effect on the next rising edge when unlinked. Linked, it shows only in the window that follows the next overflow, so the width and the indicator are checked at the end of the window after the write. The release flag and the indicator lag the link input by one cycle and are read one falling edge after it changes.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        EDGE_NONE   = 2'b00,
        EDGE_TOGGLE = 2'b01,
        EDGE_CLEAR  = 2'b10,
        EDGE_SET    = 2'b11
    } cmp_action_e;

endpackage

// File: rtl/pwm_cmp_bank.sv
// Compare registers with high-byte staging; the low byte completes a load.
module pwm_cmp_bank
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 2,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int HI_W  = CNT_W - BYTE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [SEL_W-1:0]           wr_sel_i,
    input  logic                       wr_hi_i,
    input  logic [BYTE_W-1:0]          wr_data_i,
    output logic [NCH-1:0][CNT_W-1:0]  cmp_o,
    output logic [NCH-1:0]             done_o
);

    typedef struct packed {
        logic [HI_W-1:0]  stage;
        logic [CNT_W-1:0] value;
    } slot_t;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_slot
        slot_t slot_d, slot_q;
        logic  sel_hit;

        assign sel_hit = wr_en_i && (wr_sel_i == SEL_W'(ch));

        always_comb begin
            slot_d = slot_q;
            if (sel_hit && wr_hi_i) begin
                slot_d.stage = wr_data_i[HI_W-1:0];
            end
            if (sel_hit && !wr_hi_i) begin
                slot_d.value = {slot_q.stage, wr_data_i};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign cmp_o[ch]  = slot_q.value;
        assign done_o[ch] = sel_hit && !wr_hi_i;
    end

endmodule

// File: rtl/pwm_pair_ctrl.sv
// Active-register selection with a swap armed by writes to the idle register.
module pwm_pair_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_en_i,
    input  logic       ovf_i,
    input  logic [1:0] done_i,
    output logic       act_o
);

    typedef struct packed {
        logic act;
        logic arm;
    } sel_state_t;

    sel_state_t sel_d, sel_q;
    logic       swap_now;
    logic       idle_done;

    always_comb begin
        sel_d     = sel_q;
        swap_now  = ovf_i && sel_q.arm;
        idle_done = sel_q.act ? done_i[0] : done_i[1];
        if (!link_en_i) begin
            sel_d.act = 1'b0;
            sel_d.arm = 1'b0;
        end else begin
            if (swap_now) begin
                sel_d.act = ~sel_q.act;
                sel_d.arm = 1'b0;
            end else if (idle_done) begin
                sel_d.arm = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign act_o = sel_q.act;

endmodule

// File: rtl/pwm_wave_gen.sv
// One channel output: overflow toggle first, then the compare action.
module pwm_wave_gen
    import pwm_pair_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_en_i,
    input  cmp_action_e action_i,
    input  logic        tov_en_i,
    input  logic        ovf_i,
    input  logic        hit_i,
    output logic        out_o
);

    typedef struct packed {
        logic out;
    } wave_state_t;

    wave_state_t wave_d, wave_q;

    always_comb begin
        wave_d = wave_q;
        if (mode_en_i) begin
            if (ovf_i && tov_en_i) begin
                wave_d.out = ~wave_q.out;
            end else if (hit_i) begin
                unique case (action_i)
                    EDGE_TOGGLE: wave_d.out = ~wave_q.out;
                    EDGE_CLEAR:  wave_d.out = 1'b0;
                    EDGE_SET:    wave_d.out = 1'b1;
                    default:     wave_d.out = wave_q.out;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_q <= '0;
        end else begin
            wave_q <= wave_d;
        end
    end

    assign out_o = wave_q.out;

endmodule

// File: rtl/pwm_pair_buf.sv
module pwm_pair_buf
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ovf_i,
    input  logic             link_en_i,
    input  logic             even_mode_a_i,
    input  logic [1:0]       even_act_i,
    input  logic             even_tov_i,
    input  logic             odd_mode_a_i,
    input  logic [1:0]       odd_act_i,
    input  logic             odd_tov_i,
    input  logic             wr_en_i,
    input  logic             wr_odd_i,
    input  logic             wr_hi_i,
    input  logic [7:0]       wr_data_i,
    output logic [1:0]       pwm_o,
    output logic [1:0]       pwm_oe_o,
    output logic             odd_port_ctl_o,
    output logic             act_sel_o
);

    localparam int NCH = 2;

    typedef struct packed {
        logic link;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [NCH-1:0][CNT_W-1:0] cmp_val;
    logic [NCH-1:0]            lo_done;
    logic                      act_sel;
    logic [NCH-1:0][CNT_W-1:0] src_val;
    logic [NCH-1:0]            hit;
    logic [NCH-1:0]            mode_en;
    logic [NCH-1:0]            tov_en;
    cmp_action_e               action [NCH];

    always_comb begin
        top_d      = top_q;
        top_d.link = link_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    pwm_cmp_bank #(
        .CNT_W (CNT_W),
        .NCH   (NCH)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_odd_i),
        .wr_hi_i   (wr_hi_i),
        .wr_data_i (wr_data_i),
        .cmp_o     (cmp_val),
        .done_o    (lo_done)
    );

    pwm_pair_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_en_i (link_en_i),
        .ovf_i     (ovf_i),
        .done_i    (lo_done),
        .act_o     (act_sel)
    );

    // Mode-B overrides mode-A on the even side and silences the odd side.
    assign mode_en[0] = top_q.link | even_mode_a_i;
    assign mode_en[1] = odd_mode_a_i & ~top_q.link;
    assign tov_en[0]  = even_tov_i;
    assign tov_en[1]  = odd_tov_i;
    assign action[0]  = cmp_action_e'(even_act_i);
    assign action[1]  = cmp_action_e'(odd_act_i);
    assign src_val[0] = cmp_val[act_sel];
    assign src_val[1] = cmp_val[1];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        assign hit[ch] = (cnt_i == src_val[ch]);

        pwm_wave_gen u_wave (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_en_i (mode_en[ch]),
            .action_i  (action[ch]),
            .tov_en_i  (tov_en[ch]),
            .ovf_i     (ovf_i),
            .hit_i     (hit[ch]),
            .out_o     (pwm_o[ch])
        );

        assign pwm_oe_o[ch] = mode_en[ch] && (action[ch] != EDGE_NONE);
    end

    assign odd_port_ctl_o = top_q.link;
    assign act_sel_o      = act_sel;

endmodule

// File: rtl/pwm_pair_buf_chk.sv
module pwm_pair_buf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ovf_i,
    input logic       link_en_i,
    input logic       even_mode_a_i,
    input logic       even_tov_i,
    input logic       wr_en_i,
    input logic       wr_hi_i,
    input logic [1:0] pwm_o,
    input logic [1:0] pwm_oe_o,
    input logic       odd_port_ctl_o,
    input logic       act_sel_o
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    // R5
    swap_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_sel_o) |-> ($past(ovf_i) || !$past(link_en_i)));

    // R2
    odd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(link_en_i)) |-> (odd_port_ctl_o && !pwm_oe_o[1]));

    // R8
    ovf_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && even_tov_i && (odd_port_ctl_o || even_mode_a_i))
        |=> (pwm_o[0] != $past(pwm_o[0])));

    // R10
    unlinked_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !odd_port_ctl_o |-> !act_sel_o);

    // R3
    hi_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_hi_i && !ovf_i && link_en_i) |=> $stable(act_sel_o));

endmodule

bind pwm_pair_buf pwm_pair_buf_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ovf_i          (ovf_i),
    .link_en_i      (link_en_i),
    .even_mode_a_i  (even_mode_a_i),
    .even_tov_i     (even_tov_i),
    .wr_en_i        (wr_en_i),
    .wr_hi_i        (wr_hi_i),
    .pwm_o          (pwm_o),
    .pwm_oe_o       (pwm_oe_o),
    .odd_port_ctl_o (odd_port_ctl_o),
    .act_sel_o      (act_sel_o)
);

// File: tb/pwm_pair_buf_tb.sv
module pwm_pair_buf_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = '0;
    logic        ovf = 1'b0;
    logic        link_en = 1'b0;
    logic        even_mode_a = 1'b0;
    logic [1:0]  even_act = 2'b00;
    logic        even_tov = 1'b0;
    logic        odd_mode_a = 1'b0;
    logic [1:0]  odd_act = 2'b00;
    logic        odd_tov = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_odd = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  pwm;
    logic [1:0]  pwm_oe;
    logic        odd_port_ctl;
    logic        act_sel;

    int total = 0;
    int bad = 0;
    int modv = 15;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwm_pair_buf #(.CNT_W(16)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cnt_i          (cnt),
        .ovf_i          (ovf),
        .link_en_i      (link_en),
        .even_mode_a_i  (even_mode_a),
        .even_act_i     (even_act),
        .even_tov_i     (even_tov),
        .odd_mode_a_i   (odd_mode_a),
        .odd_act_i      (odd_act),
        .odd_tov_i      (odd_tov),
        .wr_en_i        (wr_en),
        .wr_odd_i       (wr_odd),
        .wr_hi_i        (wr_hi),
        .wr_data_i      (wr_data),
        .pwm_o          (pwm),
        .pwm_oe_o       (pwm_oe),
        .odd_port_ctl_o (odd_port_ctl),
        .act_sel_o      (act_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cnt = '0; ovf = 1'b0; link_en = 1'b0;
        even_mode_a = 1'b0; even_act = 2'b00; even_tov = 1'b0;
        odd_mode_a = 1'b0; odd_act = 2'b00; odd_tov = 1'b0;
        wr_en = 1'b0; wr_odd = 1'b0; wr_hi = 1'b0; wr_data = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr16(input bit odd, input logic [15:0] v);
        wr_en = 1'b1; wr_odd = odd; wr_hi = 1'b1; wr_data = v[15:8];
        @(negedge clk);
        wr_hi = 1'b0; wr_data = v[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One full counter period starting with the overflow; nw: 0 none, 1 one
    // write, 2 two writes, 3 high byte of v1 only.
    task automatic run_period(input int nw, input bit wodd, input logic [15:0] v1,
                              input logic [15:0] v2, input int at,
                              output int hi0, output int hi1);
        hi0 = 0; hi1 = 0;
        for (int i = 0; i <= modv; i++) begin
            cnt = 16'(i); ovf = (i == 0);
            wr_en = 1'b0; wr_hi = 1'b0; wr_odd = wodd; wr_data = '0;
            if (nw >= 1 && i == at) begin wr_en = 1'b1; wr_hi = 1'b1; wr_data = v1[15:8]; end
            if ((nw == 1 || nw == 2) && i == at + 1) begin wr_en = 1'b1; wr_data = v1[7:0]; end
            if (nw == 2 && i == at + 3) begin wr_en = 1'b1; wr_hi = 1'b1; wr_data = v2[15:8]; end
            if (nw == 2 && i == at + 4) begin wr_en = 1'b1; wr_data = v2[7:0]; end
            @(negedge clk);
            hi0 += int'(pwm[0]);
            hi1 += int'(pwm[1]);
        end
        wr_en = 1'b0; ovf = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int h0, h1, cur, v;
        bit eact;

        // R1: reset state
        do_reset();
        check(pwm == 2'b00, "R1 outputs", int'(pwm), 0);
        check(pwm_oe == 2'b00, "R1 enables", int'(pwm_oe), 0);
        check(act_sel == 1'b0, "R1 active", int'(act_sel), 0);
        check(odd_port_ctl == 1'b0, "R1 release", int'(odd_port_ctl), 0);

        // R4: unlinked clear-on-compare sweep
        modv = 15;
        for (int c = 1; c <= modv; c++) begin
            do_reset();
            wr16(1'b0, 16'(c));
            even_mode_a = 1'b1; even_act = 2'b10; even_tov = 1'b1;
            for (int p = 0; p < 2; p++) begin
                run_period(0, 1'b0, '0, '0, 0, h0, h1);
                check(h0 == c, "R4 high count", h0, c);
            end
        end

        // R3: unlinked, high byte alone leaves the compare value
        do_reset();
        wr16(1'b0, 16'd6);
        even_mode_a = 1'b1; even_act = 2'b10; even_tov = 1'b1;
        run_period(3, 1'b0, 16'h0100, '0, 8, h0, h1);
        run_period(0, 1'b0, '0, '0, 0, h0, h1);
        check(h0 == 6, "R3 hi byte only", h0, 6);

        // R2 + R5: linked chain
        do_reset();
        wr16(1'b0, 16'd3);
        even_act = 2'b10; even_tov = 1'b1;
        odd_mode_a = 1'b1; odd_act = 2'b11; odd_tov = 1'b1;
        cnt = 16'(modv);
        link_en = 1'b1;
        @(negedge clk);
        check(odd_port_ctl == 1'b1, "R2 release", int'(odd_port_ctl), 1);
        check(pwm_oe == 2'b01, "R2 enables", int'(pwm_oe), 1);
        check(act_sel == 1'b0, "R5 even first", int'(act_sel), 0);
        cur = 3; eact = 1'b0;
        run_period(0, 1'b0, '0, '0, 0, h0, h1);
        check(h0 == cur, "R5 initial width", h0, cur);
        for (int k = 0; k < 10; k++) begin
            v = 4 + k;
            run_period(1, ~eact, 16'(v), '0, 6, h0, h1);
            check(h0 == cur, "R5 width", h0, cur);
            check(act_sel == eact, "R5 indicator", int'(act_sel), int'(eact));
            check(h1 == 0, "R2 odd frozen", h1, 0);
            cur = v; eact = ~eact;
        end
        // R6: last completed write wins
        run_period(2, ~eact, 16'd9, 16'd2, 4, h0, h1);
        check(h0 == cur, "R6 width before", h0, cur);
        cur = 2; eact = ~eact;
        run_period(0, 1'b0, '0, '0, 0, h0, h1);
        check(h0 == 2, "R6 last write", h0, 2);
        check(act_sel == eact, "R6 indicator", int'(act_sel), int'(eact));
        // R3: linked high byte only arms nothing
        run_period(3, ~eact, 16'h0100, '0, 5, h0, h1);
        run_period(0, 1'b0, '0, '0, 0, h0, h1);
        check(h0 == 2, "R3 linked width", h0, 2);
        check(act_sel == eact, "R3 no swap", int'(act_sel), int'(eact));
        // R10: unlink
        link_en = 1'b0;
        @(negedge clk);
        check(act_sel == 1'b0, "R10 indicator", int'(act_sel), 0);
        check(odd_port_ctl == 1'b0, "R10 release", int'(odd_port_ctl), 0);

        // R7: 254 -> 1 on a 256-count period
        do_reset();
        modv = 255;
        wr16(1'b0, 16'h00FE);
        even_act = 2'b10; even_tov = 1'b1;
        cnt = 16'(modv);
        link_en = 1'b1;
        @(negedge clk);
        run_period(0, 1'b0, '0, '0, 0, h0, h1);
        check(h0 == 254, "R7 wide", h0, 254);
        run_period(1, 1'b1, 16'h0001, '0, 100, h0, h1);
        check(h0 == 254, "R7 before swap", h0, 254);
        run_period(0, 1'b0, '0, '0, 0, h0, h1);
        check(h0 == 1, "R7 narrow", h0, 1);
        check(act_sel == 1'b1, "R7 indicator", int'(act_sel), 1);

        // R8: compare beyond range, toggle only
        do_reset();
        modv = 15;
        wr16(1'b0, 16'd20);
        even_mode_a = 1'b1; even_act = 2'b10; even_tov = 1'b1;
        for (int p = 0; p < 3; p++) begin
            run_period(0, 1'b0, '0, '0, 0, h0, h1);
            check(h0 == ((p % 2 == 0) ? 16 : 0), "R8 out of range", h0, (p % 2 == 0) ? 16 : 0);
        end
        // R8: compare at 0 coincides with overflow, overflow wins
        do_reset();
        even_mode_a = 1'b1; even_act = 2'b10; even_tov = 1'b1;
        for (int p = 0; p < 2; p++) begin
            run_period(0, 1'b0, '0, '0, 0, h0, h1);
            check(h0 == ((p == 0) ? 16 : 0), "R8 precedence", h0, (p == 0) ? 16 : 0);
        end

        // R9: odd toggle-on-compare, no overflow toggle
        do_reset();
        wr16(1'b1, 16'd5);
        odd_mode_a = 1'b1; odd_act = 2'b01; odd_tov = 1'b0;
        for (int p = 0; p < 3; p++) begin
            run_period(0, 1'b0, '0, '0, 0, h0, h1);
            check(h1 == ((p % 2 == 0) ? 11 : 5), "R9 toggle", h1, (p % 2 == 0) ? 11 : 5);
        end
        // R9: odd set-on-compare with overflow toggle
        do_reset();
        wr16(1'b1, 16'd5);
        odd_mode_a = 1'b1; odd_act = 2'b11; odd_tov = 1'b1;
        for (int p = 0; p < 3; p++) begin
            run_period(0, 1'b0, '0, '0, 0, h0, h1);
            check(h1 == ((p == 0) ? 16 : 11), "R9 set", h1, (p == 0) ? 16 : 11);
        end
        check(pwm_oe == 2'b10, "R9 enables", int'(pwm_oe), 2);
        odd_act = 2'b00;
        @(negedge clk);
        check(pwm_oe == 2'b00, "R9 none drives nothing", int'(pwm_oe), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule